// File: doc/BRIEF.md
# Adaptive Receive Threshold Controller

This block sets the detection threshold for a receiver that sees a bipolar pulse signal on a line as a stream of digitized amplitude samples. It follows the largest sample magnitude seen so far with a peak tracker and reports a threshold of about 52.5 % of that peak. Two registered flags report whether the current sample lies above the threshold (a positive pulse) or below its negative (a negative pulse).

When reset, or when the downstream decoder flags a bad signal, the tracker returns to a default peak and freezes. It stays frozen until a line pause is reported, and then resumes adapting. The tracker rises toward larger samples (attack) and decays slowly while samples stay small. Both rates are faster while the receiver is unsynchronized, so the threshold settles quickly during acquisition and stays steady once the receiver has locked.

Top module: `rx_thresh_ctrl`

## Requirements
- R1: `thr_o` equals (peak × 538) >> 10 of the registered peak value at all times, so with the default peak of 200 it reads 105.
- R2: While `rst_ni` is low, the peak is the default (200), the tracker is frozen, and `pos_o` and `neg_o` are 0.
- R3: A cycle with `err_i` high loads the default peak and freezes the tracker at the next clock edge. This takes priority over `pause_i` in the same cycle.
- R4: While frozen, samples have no effect on the peak, so `thr_o` is held. A cycle with `pause_i` high (and `err_i` low) only releases the freeze and leaves the peak unchanged in that cycle.
- R5: When the tracker is free and |sample| > peak, the peak grows by (|sample| − peak) >> A. A is 1 when `sync_i` is 0 and 3 when `sync_i` is 1.
- R6: When the tracker is free, a decay counter wraps every D free cycles. D is 4 unsynchronized and 16 synchronized. The counter is cleared while frozen and on a pause cycle. On a wrap cycle with no attack, the peak drops by peak >> S, where S is 3 unsynchronized and 5 synchronized.
- R7: `pos_o` is registered. After each clock edge it shows whether the sample before that edge, read as two's complement, was greater than the `thr_o` shown before the edge.
- R8: `neg_o` is registered in the same way. It shows whether the sample was less than −`thr_o`. `pos_o` and `neg_o` are never both 1.
- R9: With `SIGNED_IN` = 0, samples are offset binary: the code with only the MSB set means zero. Outputs then match the signed variant driven with the same amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Amplitude sample, one per clock |
| pause_i | input | 1 | Line pause seen; releases the freeze |
| err_i | input | 1 | Bad signal seen; restores the default and freezes |
| sync_i | input | 1 | Receiver synchronized; selects the slow rates |
| thr_o | output | SAMPLE_W | Current threshold magnitude |
| pos_o | output | 1 | Positive pulse detect, registered |
| neg_o | output | 1 | Negative pulse detect, registered |

## Verification
The properties assume that the error and pause strobes are single-bit, synchronous and free of unknowns after reset. They also assume that the sample magnitude fits the peak register, which holds because the peak width equals the sample width. The rise and no-rise properties rely on the rule that only an error can raise the peak without a larger sample. The bench therefore checks them only in cycles where `err_i` is low. The stimulus changes every input only on the falling clock edge and drives the error and pause strobes one cycle at a time, including one cycle with both high. Samples include the most negative code, so the magnitude path is exercised at its limit.

// File: rtl/rx_thr_pkg.sv
package rx_thr_pkg;
   typedef struct packed {
      logic [3:0] atk_sh;
      logic [3:0] dec_sh;
      logic [7:0] dec_div;
   } rate_cfg_t;

   function automatic rate_cfg_t make_rate(input int atk, input int dec, input int div);
      rate_cfg_t r;
      r.atk_sh  = 4'(atk);
      r.dec_sh  = 4'(dec);
      r.dec_div = 8'(div);
      return r;
   endfunction
endpackage

// File: rtl/rx_sample_fe.sv
module rx_sample_fe #(
   parameter int SAMPLE_W  = 10,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic [SAMPLE_W-1:0] raw_i,
   output logic [SAMPLE_W-1:0] cen_o,
   output logic [SAMPLE_W-1:0] mag_o
);
   localparam logic [SAMPLE_W-1:0] MSB_ONLY = {1'b1, {(SAMPLE_W-1){1'b0}}};

   generate
      if (SIGNED_IN) begin : g_twos
         assign cen_o = raw_i;
      end else begin : g_offset
         assign cen_o = raw_i ^ MSB_ONLY;
      end
   endgenerate

   assign mag_o = cen_o[SAMPLE_W-1] ? (~cen_o + 1'b1) : cen_o;
endmodule

// File: rtl/rx_peak_track.sv
module rx_peak_track
   import rx_thr_pkg::*;
#(
   parameter int        SAMPLE_W = 10,
   parameter int        DEF_PEAK = 200,
   parameter rate_cfg_t FAST     = '0,
   parameter rate_cfg_t SLOW     = '0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [SAMPLE_W-1:0] mag_i,
   input  logic                pause_i,
   input  logic                err_i,
   input  logic                sync_i,
   output logic [SAMPLE_W-1:0] peak_o,
   output logic                lock_o
);
   localparam logic [SAMPLE_W-1:0] DEF_P = SAMPLE_W'(DEF_PEAK);

   rate_cfg_t           rate;
   logic [7:0]          cnt_q, cnt_d;
   logic [SAMPLE_W-1:0] peak_q, peak_d, diff;
   logic                lock_q, lock_d, attack, tick;

   always_comb begin
      rate   = sync_i ? SLOW : FAST;
      attack = mag_i > peak_q;
      diff   = mag_i - peak_q;
      tick   = cnt_q >= (rate.dec_div - 8'd1);
      peak_d = peak_q;
      lock_d = lock_q;
      cnt_d  = '0;
      if (err_i) begin
         peak_d = DEF_P;
         lock_d = 1'b1;
      end else if (pause_i) begin
         lock_d = 1'b0;
      end else if (!lock_q) begin
         cnt_d = tick ? 8'd0 : cnt_q + 8'd1;
         if (attack)
            peak_d = peak_q + (diff >> rate.atk_sh);
         else if (tick)
            peak_d = peak_q - (peak_q >> rate.dec_sh);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         peak_q <= DEF_P;
         lock_q <= 1'b1;
         cnt_q  <= '0;
      end else begin
         peak_q <= peak_d;
         lock_q <= lock_d;
         cnt_q  <= cnt_d;
      end
   end

   assign peak_o = peak_q;
   assign lock_o = lock_q;
endmodule

// File: rtl/rx_thr_scale.sv
module rx_thr_scale #(
   parameter int SAMPLE_W  = 10,
   parameter int SCALE_NUM = 538,
   parameter int SCALE_SH  = 10
) (
   input  logic [SAMPLE_W-1:0] peak_i,
   output logic [SAMPLE_W-1:0] thr_o
);
   localparam int PROD_W = SAMPLE_W + SCALE_SH;

   logic [PROD_W-1:0] prod;

   assign prod  = PROD_W'(peak_i) * PROD_W'(SCALE_NUM);
   assign thr_o = SAMPLE_W'(prod >> SCALE_SH);
endmodule

// File: rtl/rx_pulse_cmp.sv
module rx_pulse_cmp #(
   parameter int SAMPLE_W = 10
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [SAMPLE_W-1:0] cen_i,
   input  logic [SAMPLE_W-1:0] thr_i,
   output logic                pos_o,
   output logic                neg_o
);
   logic signed [SAMPLE_W:0] s_ext, t_ext;

   assign s_ext = $signed({cen_i[SAMPLE_W-1], cen_i});
   assign t_ext = $signed({1'b0, thr_i});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_o <= 1'b0;
         neg_o <= 1'b0;
      end else begin
         pos_o <= s_ext > t_ext;
         neg_o <= s_ext < -t_ext;
      end
   end
endmodule

// File: rtl/rx_thresh_ctrl.sv
module rx_thresh_ctrl
   import rx_thr_pkg::*;
#(
   parameter int SAMPLE_W  = 10,
   parameter bit SIGNED_IN = 1'b1,
   parameter int DEF_PEAK  = 200,
   parameter int SCALE_NUM = 538,
   parameter int SCALE_SH  = 10,
   parameter int ATK_FAST  = 1,
   parameter int DEC_FAST  = 3,
   parameter int DIV_FAST  = 4,
   parameter int ATK_SLOW  = 3,
   parameter int DEC_SLOW  = 5,
   parameter int DIV_SLOW  = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                pause_i,
   input  logic                err_i,
   input  logic                sync_i,
   output logic [SAMPLE_W-1:0] thr_o,
   output logic                pos_o,
   output logic                neg_o
);
   localparam rate_cfg_t FAST = make_rate(ATK_FAST, DEC_FAST, DIV_FAST);
   localparam rate_cfg_t SLOW = make_rate(ATK_SLOW, DEC_SLOW, DIV_SLOW);

   generate
      if (SAMPLE_W < 4 || SAMPLE_W > 24) begin : g_bad_w
         $error("SAMPLE_W out of range");
      end
      if (DEF_PEAK < 1 || DEF_PEAK > (1 << (SAMPLE_W - 1))) begin : g_bad_def
         $error("DEF_PEAK must fit the sample magnitude");
      end
      if (SCALE_NUM >= (1 << SCALE_SH)) begin : g_bad_scale
         $error("threshold scale must be below one");
      end
      if (DIV_FAST < 1 || DIV_SLOW > 255 || DIV_SLOW < DIV_FAST) begin : g_bad_div
         $error("decay dividers out of range or misordered");
      end
      if (ATK_SLOW < ATK_FAST || DEC_SLOW < DEC_FAST || DEC_SLOW > 15 || ATK_SLOW > 15) begin : g_bad_sh
         $error("synchronized rates must not be faster than unsynchronized");
      end
   endgenerate

   logic [SAMPLE_W-1:0] cen_w, mag_w, peak_w;
   logic                lock_w;

   rx_sample_fe #(.SAMPLE_W(SAMPLE_W), .SIGNED_IN(SIGNED_IN)) u_fe (
      .raw_i (sample_i),
      .cen_o (cen_w),
      .mag_o (mag_w)
   );

   rx_peak_track #(.SAMPLE_W(SAMPLE_W), .DEF_PEAK(DEF_PEAK), .FAST(FAST), .SLOW(SLOW)) u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mag_i   (mag_w),
      .pause_i (pause_i),
      .err_i   (err_i),
      .sync_i  (sync_i),
      .peak_o  (peak_w),
      .lock_o  (lock_w)
   );

   rx_thr_scale #(.SAMPLE_W(SAMPLE_W), .SCALE_NUM(SCALE_NUM), .SCALE_SH(SCALE_SH)) u_scl (
      .peak_i (peak_w),
      .thr_o  (thr_o)
   );

   rx_pulse_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cen_i  (cen_w),
      .thr_i  (thr_o),
      .pos_o  (pos_o),
      .neg_o  (neg_o)
   );
endmodule

// File: rtl/rx_thresh_ctrl_chk.sv
module rx_thresh_ctrl_chk #(
   parameter int SAMPLE_W  = 10,
   parameter int DEF_PEAK  = 200,
   parameter int SCALE_NUM = 538,
   parameter int SCALE_SH  = 10
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                err_i,
   input logic                pause_i,
   input logic [SAMPLE_W-1:0] mag_i,
   input logic [SAMPLE_W-1:0] peak_i,
   input logic                lock_i,
   input logic [SAMPLE_W-1:0] thr_i,
   input logic                pos_i,
   input logic                neg_i
);
   localparam logic [SAMPLE_W-1:0] DEF_THR = SAMPLE_W'((DEF_PEAK * SCALE_NUM) >> SCALE_SH);

   // R3: an error restores the default threshold and freezes
   assert_default_on_error_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i |=> (thr_i == DEF_THR) && lock_i);

   // R4: frozen tracker holds its threshold unless an error arrives
   assert_hold_while_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_i && !err_i) |=> $stable(thr_i));

   // R5: attack never lowers the threshold
   assert_attack_rises_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lock_i && !err_i && !pause_i && (mag_i > peak_i)) |=> (thr_i >= $past(thr_i)));

   // R6: without a larger sample or an error the threshold cannot rise
   assert_no_rise_without_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!err_i && (mag_i <= peak_i)) |=> (thr_i <= $past(thr_i)));

   // R8: the two detect flags are mutually exclusive
   assert_exclusive_detect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pos_i && neg_i));
endmodule

bind rx_thresh_ctrl rx_thresh_ctrl_chk #(
   .SAMPLE_W(SAMPLE_W), .DEF_PEAK(DEF_PEAK), .SCALE_NUM(SCALE_NUM), .SCALE_SH(SCALE_SH)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .err_i   (err_i),
   .pause_i (pause_i),
   .mag_i   (mag_w),
   .peak_i  (peak_w),
   .lock_i  (lock_w),
   .thr_i   (thr_o),
   .pos_i   (pos_o),
   .neg_i   (neg_o)
);

// File: tb/sim_rx_thresh_ctrl.sv
module sim_rx_thresh_ctrl;
   localparam int W   = 10;
   localparam int DEF = 200;

   typedef struct {
      int    thr;
      bit    pos;
      bit    neg;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] smp = '0, smp_u;
   logic         pause = 1'b0, err = 1'b0, sync = 1'b0;
   logic [W-1:0] thr0, thr1;
   logic         pos0, neg0, pos1, neg1;

   int   checks = 0, errors = 0;
   exp_t q[$];
   int   m_peak = DEF, m_cnt = 0;
   bit   m_lock = 1'b1;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   assign smp_u = smp ^ {1'b1, {(W-1){1'b0}}};

   rx_thresh_ctrl #(.SAMPLE_W(W), .SIGNED_IN(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .pause_i(pause), .err_i(err),
      .sync_i(sync), .thr_o(thr0), .pos_o(pos0), .neg_o(neg0));

   rx_thresh_ctrl #(.SAMPLE_W(W), .SIGNED_IN(1'b0)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .sample_i(smp_u), .pause_i(pause), .err_i(err),
      .sync_i(sync), .thr_o(thr1), .pos_o(pos1), .neg_o(neg1));

   function automatic int thr_of(input int p);
      return (p * 538) >> 10;
   endfunction

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and predicts the result
   task automatic step(input int s, input bit p, input bit e, input bit sy, input string tag);
      exp_t x;
      int   mag, t, atk, dec, div;
      bit   tick;
      @(negedge clk);
      smp = W'(s); pause = p; err = e; sync = sy;
      mag = (s < 0) ? -s : s;
      t = thr_of(m_peak);
      x.pos = s > t;
      x.neg = s < -t;
      atk = sy ? 3 : 1; dec = sy ? 5 : 3; div = sy ? 16 : 4;
      if (e) begin
         m_peak = DEF; m_lock = 1'b1; m_cnt = 0;
      end else if (p) begin
         m_lock = 1'b0; m_cnt = 0;
      end else if (m_lock) begin
         m_cnt = 0;
      end else begin
         tick  = m_cnt >= div - 1;
         m_cnt = tick ? 0 : m_cnt + 1;
         if (mag > m_peak) m_peak = m_peak + ((mag - m_peak) >> atk);
         else if (tick)    m_peak = m_peak - (m_peak >> dec);
      end
      x.thr = thr_of(m_peak);
      x.tag = tag;
      q.push_back(x);
   endtask

   // monitor: compares after each rising edge
   always @(posedge clk) begin
      #2;
      if (rst_n && q.size() > 0) begin
         exp_t x;
         x = q.pop_front();
         check(thr0 == W'(x.thr), x.tag, "thr", int'(thr0), x.thr);
         check(pos0 == x.pos, {x.tag, " R7"}, "pos", int'(pos0), int'(x.pos));
         check(neg0 == x.neg, {x.tag, " R8"}, "neg", int'(neg0), int'(x.neg));
         check(thr1 == W'(x.thr) && pos1 == x.pos && neg1 == x.neg, "R9", "offset thr",
               int'(thr1), x.thr);
      end
   end

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      check(thr0 == 10'd105, "R2", "reset thr", int'(thr0), 105);
      check(!pos0 && !neg0, "R2", "reset flags", int'({pos0, neg0}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R4: frozen after reset, large samples ignored
      for (int i = 0; i < 5; i++) step(400, 0, 0, 0, "R4 frozen");
      step(-300, 0, 0, 0, "R4 frozen neg");
      // R4: pause only unlocks
      step(450, 1, 0, 0, "R4 pause");
      // R5: fast attack
      for (int i = 0; i < 6; i++) step(400, 0, 0, 0, "R5 fast attack");
      step(60, 0, 0, 0, "R1 small");
      // R6: fast decay
      for (int i = 0; i < 24; i++) step(0, 0, 0, 0, "R6 fast decay");
      // R8: negative pulses and most negative code
      for (int i = 0; i < 4; i++) step(-450, 0, 0, 0, "R8 neg attack");
      step(-512, 0, 0, 0, "R8 min code");
      step(-100, 0, 0, 0, "R8 neg small");
      // R3: error restores default, samples ignored afterwards
      step(10, 0, 1, 0, "R3 error");
      for (int i = 0; i < 3; i++) step(500, 0, 0, 0, "R3 frozen after error");
      step(0, 1, 0, 0, "R4 pause");
      for (int i = 0; i < 8; i++) step(0, 0, 0, 0, "R6 decay from default");
      // R3: error wins over pause
      step(0, 1, 1, 0, "R3 error beats pause");
      step(480, 0, 0, 0, "R3 still frozen");
      step(0, 1, 0, 1, "R4 pause sync");
      // R5: slow attack, R6: slow decay
      for (int i = 0; i < 6; i++) step(480, 0, 0, 1, "R5 slow attack");
      for (int i = 0; i < 40; i++) step(-20, 0, 0, 1, "R6 slow decay");
      // R1: mixed levels around the threshold
      for (int i = 0; i < 12; i++) step((i % 3 == 0) ? 250 : ((i % 3 == 1) ? -250 : 5), 0, 0, i[2], "R1 mixed");
      step(0, 0, 0, 0, "R1 tail");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule